// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on one serial pin. Software puts a byte into a holding register. At a bit-time tick, while the transmitter is enabled, the byte moves into a shift register. The shift register sends a start bit, the data bits with the least significant bit first, and a stop bit. The holding register is then free for the next byte, so back-to-back characters go out without a gap.

The transmitter can also send two special characters. An idle character is queued by turning the enable off and back on during a character. A break character is queued with a request pulse. An inversion control flips every level driven on the pin.

Two status flags are available. One shows that the holding register is empty. The other shows that the whole transmitter has gone quiet. These flags are routed to an interrupt request, or, for the empty flag, to a DMA service request.

Top module: `uart_tx_dbuf`

## Requirements
- R1: A data character is 10 bit intervals on the line: a 0, then data bits 0 to 7 in that order, then a 1. A character starts at the clock edge that carries a bit tick, when the enable is high and the shifter is either idle or showing its final bit. Each later level appears on the edge of the next bit tick.
- R2: When nothing is being shifted, the pin rests at logic 1 XOR the inversion input. This holds whether or not the enable is high.
- R3: With the inversion input high, every level on the pin is inverted. This covers start, data, stop, idle and break levels.
- R4: `hold_empty` is 1 after reset. A write clears it on the following edge. It returns to 1 on the edge where the byte moves into the shifter.
- R5: `tx_done` is 1 only when all four of these are true: the shifter is idle, the holding register is empty, and no break or idle character is pending. It is 1 after reset and 0 after a write.
- R6: Let the empty interrupt enable be set. If the DMA enable is 0, `hold_empty` drives `irq`. If the DMA enable is 1, `hold_empty` drives `dma_req` instead and no longer drives `irq`.
- R7: When the done interrupt enable is set, `tx_done` drives `irq`. This is ORed with the empty path of R6.
- R8: Suppose the enable falls and rises again while a data character is on its start or data bits. Then one idle character (10 intervals of 1) is sent after that character and before any further data.
- R9: Suppose the enable falls during a data character and rises again only once that character's stop bit is showing, or later. Then the byte in the holding register is discarded and `hold_empty` becomes 1.
- R10: A pulse on `brk_req` while the enable is high queues a break character: 10 intervals of 0, then 1 interval of 1. A pending break goes out before a pending idle character or held data.
- R11: While the enable is low, a character already shifting completes, but no new character is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable |
| invert | input | 1 | Invert all output levels |
| brk_req | input | 1 | Pulse to queue a break character |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to write |
| ie_empty | input | 1 | Empty-flag request enable |
| ie_done | input | 1 | Done-flag interrupt enable |
| dma_en | input | 1 | Steer the empty flag to DMA |
| tx_out | output | 1 | Serial output pin |
| hold_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Transmission complete flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA service request |

## Verification
The line output is tested with random bytes sent as single characters and as back-to-back pairs. The inversion input is chosen at random for each run, so both a bit-order error and a missed inversion show up as wrong levels at specific intervals. Directed runs toggle the enable at two moments: on a data bit, and on the stop bit. These two runs separate the queued-idle outcome from the discarded-byte outcome. They also check that a held byte waits behind the idle or break character. A disabled run shows that a loaded byte stays held, and a random sweep of the three enables checks the request routing against the flag states.

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              invert,
  input  logic              brk_req,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ie_empty,
  input  logic              ie_done,
  input  logic              dma_en,
  output logic              tx_out,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              irq,
  output logic              dma_req
);

  localparam int FRM_LEN = DATA_W + 2;
  localparam int BRK_LEN = DATA_W + 3;
  localparam int CW      = $clog2(BRK_LEN + 1);

  typedef enum logic [1:0] {K_NONE, K_DATA, K_IDLE, K_BRK} kind_t;

  kind_t              kind;
  logic [BRK_LEN-1:0] shreg;
  logic [CW-1:0]      len, idx;
  logic [DATA_W-1:0]  hold_data;
  logic               hold_full, brk_pend, idle_pend, tog, en_q;

  wire busy    = kind != K_NONE;
  wire last    = busy && idx == len - CW'(1);
  wire free    = !busy || last;
  wire en_rise = tx_en && !en_q;
  wire early   = kind == K_DATA && idx < CW'(FRM_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind      <= K_NONE;
      shreg     <= '1;
      len       <= '0;
      idx       <= '0;
      hold_data <= '0;
      hold_full <= 1'b0;
      brk_pend  <= 1'b0;
      idle_pend <= 1'b0;
      tog       <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (bit_tick && free) begin
        idx <= '0;
        if (tx_en && brk_pend) begin
          kind     <= K_BRK;
          shreg    <= {1'b1, {(BRK_LEN-1){1'b0}}};
          len      <= CW'(BRK_LEN);
          brk_pend <= 1'b0;
        end else if (tx_en && idle_pend) begin
          kind      <= K_IDLE;
          shreg     <= '1;
          len       <= CW'(FRM_LEN);
          idle_pend <= 1'b0;
        end else if (tx_en && hold_full) begin
          kind      <= K_DATA;
          shreg     <= {2'b11, hold_data, 1'b0};
          len       <= CW'(FRM_LEN);
          hold_full <= 1'b0;
        end else begin
          kind  <= K_NONE;
          shreg <= '1;
        end
      end else if (bit_tick && busy) begin
        shreg <= {1'b1, shreg[BRK_LEN-1:1]};
        idx   <= idx + CW'(1);
      end

      if (!tx_en && kind == K_DATA) tog <= 1'b1;
      else if (en_rise) tog <= 1'b0;

      if (en_rise && tog) begin
        if (early) idle_pend <= 1'b1;
        else hold_full <= 1'b0;
      end

      if (brk_req && tx_en) brk_pend <= 1'b1;

      if (wr_valid) begin
        hold_data <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end

  assign tx_out     = (busy ? shreg[0] : 1'b1) ^ invert;
  assign hold_empty = !hold_full;
  assign tx_done    = !busy && !hold_full && !brk_pend && !idle_pend;
  assign irq        = (hold_empty && ie_empty && !dma_en) || (tx_done && ie_done);
  assign dma_req    = hold_empty && ie_empty && dma_en;

  // R4
  wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !hold_empty);

  // R4
  empty_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(bit_tick || en_rise));

  // R5
  done_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> hold_empty);

  // R6
  dma_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && !ie_done) |-> !irq);

  // R11
  no_load_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> !busy);

  // R10
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BRK && idx < CW'(BRK_LEN - 1)) |-> tx_out == invert);

endmodule

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;
  localparam int CLK_NS = 20;

  logic clk = 0, rst_n = 0, bit_tick = 0, tx_en = 0, invert = 0, brk_req = 0, wr_valid = 0;
  logic [7:0] wr_data = 0;
  logic ie_empty = 0, ie_done = 0, dma_en = 0;
  logic tx_out, hold_empty, tx_done, irq, dma_req;
  int n_chk = 0, n_fail = 0, tcnt = 0;

  uart_tx_dbuf #(.DATA_W(8)) dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    tcnt     <= (tcnt == 3) ? 0 : tcnt + 1;
    bit_tick <= (tcnt == 2);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!bit_tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_data = d; wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
  endtask

  function automatic logic [15:0] frm(input logic [7:0] d);
    return {6'b0, 1'b1, d, 1'b0};
  endfunction

  task automatic exp_seq(input logic [15:0] pat, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      wait_tick();
      chk(tx_out == (pat[i] ^ invert), req, tx_out, pat[i] ^ invert);
    end
  endtask

  function automatic logic exp_irq(input logic e, input logic d);
    return (e && ie_empty && !dma_en) || (d && ie_done);
  endfunction

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_out == 1, "R2 reset level", tx_out, 1);
    chk(hold_empty == 1, "R4 reset empty", hold_empty, 1);
    chk(tx_done == 1, "R5 reset done", tx_done, 1);
    chk(irq == 0 && dma_req == 0, "R6 reset requests", {irq, dma_req}, 0);

    // R6 R7 routing sweep while idle
    for (int k = 0; k < 16; k++) begin
      {ie_empty, ie_done, dma_en} = 3'($urandom(k + 7));
      @(negedge clk);
      chk(irq == exp_irq(1, 1), "R6 R7 irq routing", irq, exp_irq(1, 1));
      chk(dma_req == (ie_empty && dma_en), "R6 dma routing", dma_req, ie_empty && dma_en);
    end

    // R11 disabled with inversion: write held, nothing sent
    invert = 1;
    wait_tick(); wr(8'h5A);
    chk(hold_empty == 0, "R4 write clears", hold_empty, 0);
    chk(tx_done == 0, "R5 write clears done", tx_done, 0);
    {ie_empty, ie_done, dma_en} = 3'b110;
    @(negedge clk);
    chk(irq == 0, "R6 R7 irq with data held", irq, 0);
    for (int i = 0; i < 12; i++) begin
      wait_tick();
      chk(tx_out == 0, "R2 R3 R11 rest level inverted", tx_out, 0);
    end
    chk(hold_empty == 0, "R11 byte held while disabled", hold_empty, 0);
    tx_en = 1;
    exp_seq(frm(8'h5A), 10, "R1 R3 inverted frame");
    wait_tick();
    chk(tx_done == 1 && tx_out == 0, "R5 done after frame", {tx_done, tx_out}, 2);
    chk(irq == 1, "R7 done interrupt", irq, 1);
    {ie_empty, ie_done, dma_en} = 3'b000;

    // random singles and back-to-back pairs (R1 R3 R4)
    for (int k = 0; k < 24; k++) begin
      invert = 1'($urandom(k * 3 + 1));
      a = 8'($urandom(k * 5 + 11));
      b = 8'($urandom(k * 7 + 13));
      wait_tick(); wr(a);
      wait_tick();
      chk(tx_out == invert, "R1 start bit", tx_out, invert);
      chk(hold_empty == 1, "R4 empty on load", hold_empty, 1);
      if (k % 2 == 1) wr(b);
      exp_seq(frm(a) >> 1, 9, "R1 R3 random frame");
      if (k % 2 == 1) exp_seq(frm(b), 10, "R1 back-to-back frame");
      wait_tick();
      chk(tx_out == !invert, "R2 rest after frame", tx_out, !invert);
    end

    // R8 queued idle character
    invert = 0; a = 8'hC3; b = 8'h81;
    wait_tick(); wr(a);
    wait_tick(); wr(b);
    exp_seq(frm(a) >> 1, 2, "R8 lead bits");
    tx_en = 0; @(negedge clk); tx_en = 1;
    exp_seq(frm(a) >> 3, 7, "R8 rest of frame");
    exp_seq(16'h03FF, 10, "R8 idle character");
    chk(tx_done == 0, "R5 not done with data held", tx_done, 0);
    exp_seq(frm(b), 10, "R8 data after idle");

    // R9 late re-enable discards held byte
    a = 8'h3C;
    wait_tick(); wr(a);
    wait_tick(); wr(8'hEE);
    exp_seq(frm(a) >> 1, 9, "R9 frame to stop bit");
    tx_en = 0; @(negedge clk); tx_en = 1; @(negedge clk);
    chk(hold_empty == 1, "R9 held byte discarded", hold_empty, 1);
    for (int i = 0; i < 12; i++) begin
      wait_tick();
      chk(tx_out == 1, "R9 nothing sent after discard", tx_out, 1);
    end
    chk(tx_done == 1, "R5 done after discard", tx_done, 1);

    // R10 break with inversion, priority over held data
    invert = 1; b = 8'h96;
    wait_tick();
    brk_req = 1; wr_data = b; wr_valid = 1;
    @(negedge clk);
    brk_req = 0; wr_valid = 0;
    chk(tx_done == 0, "R5 not done with break pending", tx_done, 0);
    exp_seq(16'h0400, 11, "R10 R3 break character");
    exp_seq(frm(b), 10, "R10 data after break");

    // R11 disable mid-frame: frame completes, next byte stays held
    invert = 0; a = 8'h71;
    wait_tick(); wr(a);
    wait_tick(); wr(8'h0F);
    exp_seq(frm(a) >> 1, 2, "R11 lead bits");
    tx_en = 0;
    exp_seq(frm(a) >> 3, 7, "R11 frame completes");
    for (int i = 0; i < 10; i++) begin
      wait_tick();
      chk(tx_out == 1, "R11 no load while disabled", tx_out, 1);
    end
    chk(hold_empty == 0, "R11 byte still held", hold_empty, 0);
    tx_en = 1; @(negedge clk);
    chk(hold_empty == 1, "R9 late enable discards", hold_empty, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule